// File: doc/BRIEF.md
# Qualified Cross-Domain Counter Snapshot

This block brings the value of a counter that advances in a slow clock domain into a much faster clock domain that is asynchronous to it. It never registers the multi-bit count bus on every fast edge, because a sample taken while the bits are switching can combine old and new bits into a value the counter never held. Instead, a single-bit qualifier from the slow side passes through a chain of synchronizer flops. The qualifier is either the counter's least significant bit or its count enable. Its change is detected as a one-cycle event. A programmable number of fast cycles then elapses, and only after that is the whole bus loaded into a holding register. By then the slow bus has long since settled.

The fast side sees the held snapshot together with a one-cycle capture strobe and a sticky valid flag. The block also keeps a local fast-domain counter. On the cycle after each capture it publishes the modulo difference between the snapshot and that local count. The intended ratio is roughly 77 fast cycles per slow cycle. The sync latency plus the settle delay must stay well below one slow period.

The snapshot output is a valid-only stream with no ready input. The slow source cannot be stalled, so there is no back-pressure. A consumer must take each snapshot in its strobe cycle, and a later capture overwrites an earlier one.

Top module: `ccs_snapshot`

## Requirements
- R1: While `fast_rst_n` is low and in the first cycle after it rises, `snap_value`, `diff_value` and `loc_count` are zero and `snap_strobe` and `snap_valid` are low.
- R2: In the default mode, every change of `slow_qual` (rising or falling) produces exactly one capture. When the qualifier stops changing, the capture count equals the number of qualifier changes.
- R3: Count as edge 1 the first rising `fast_clk` edge after `slow_qual` changes. With `SYNC_STAGES` = 2, `snap_strobe` is high in the cycle that follows edge 3 + S, where S is the settle value.
- R4: `snap_value` changes only together with a strobe. It then equals the value that `slow_count` held when the qualifier changed, and it holds that value in every cycle without a strobe.
- R5: `snap_strobe` lasts one fast cycle per capture. `snap_valid` is high whenever the strobe is high and remains high afterwards.
- R6: `snap_valid` stays low after reset, however long `slow_qual` remains unchanged, until the first capture.
- R7: `loc_count` increases by one, modulo 2^`CNT_W`, on each rising `fast_clk` edge where `loc_inc` is high, and holds otherwise.
- R8: In the cycle after a strobe, `diff_value` equals the `snap_value` minus the `loc_count` of the strobe cycle, modulo 2^`CNT_W`. In all other cycles it keeps its previous value.
- R9: `settle_cycles` (0 to 2^`SETTLE_W`-1) is taken at the fast cycle in which the qualifier edge is detected. A value of 0 gives the shortest path of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast-domain clock |
| fast_rst_n | input | 1 | Asynchronous active-low reset, fast domain |
| slow_count | input | CNT_W | Counter bus from the slow domain |
| slow_qual | input | 1 | Slow-domain qualifier (counter LSB or count enable) |
| settle_cycles | input | SETTLE_W | Fast cycles to wait after the detected edge |
| loc_inc | input | 1 | Increment for the local fast counter |
| snap_value | output | CNT_W | Held snapshot of the slow count |
| snap_strobe | output | 1 | One-cycle pulse when a new snapshot is loaded |
| snap_valid | output | 1 | High once any snapshot has been taken |
| loc_count | output | CNT_W | Local fast-domain counter |
| diff_value | output | CNT_W | Snapshot minus local count, modulo 2^CNT_W |

## Verification
The local counter can increment in the same fast cycle in which the strobe triggers the difference update. The difference must therefore use the count from before that increment. The bench toggles `loc_inc` at random in every cycle, so this coincidence occurs at many captures. Each difference is judged against the `loc_count` observed during the strobe cycle itself. The slow clock runs at a non-integer period ratio with a random start phase. The bench also skews the bits of the slow bus apart and starts near the wrap point. As a result, the high and low halves switch at different instants, and any capture made before the bus settles would show up as a wrong scoreboard value.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;
  // Which change of the synchronized qualifier counts as an event.
  typedef enum logic [0:0] {
    QUAL_ANY_EDGE = 1'b0,  // qualifier is a counter bit: both edges count
    QUAL_RISE     = 1'b1   // qualifier is a pulse-like enable: rising only
  } qual_mode_e;
endpackage

// File: rtl/ccs_sync.sv
`timescale 1ns/1ps
module ccs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ccs_edge.sv
`timescale 1ns/1ps
module ccs_edge #(
  parameter ccs_pkg::qual_mode_e MODE = ccs_pkg::QUAL_ANY_EDGE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic pulse
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  generate
    if (MODE == ccs_pkg::QUAL_ANY_EDGE) begin : g_any
      assign pulse = lvl ^ lvl_d;
    end else begin : g_rise
      assign pulse = lvl & ~lvl_d;
    end
  endgenerate
endmodule

// File: rtl/ccs_settle.sv
`timescale 1ns/1ps
module ccs_settle #(
  parameter int SETTLE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [SETTLE_W-1:0] settle,
  output logic                fire
);
  localparam logic [SETTLE_W-1:0] ONE = SETTLE_W'(1);

  logic [SETTLE_W-1:0] remain;
  logic                busy;

  // Zero delay fires with the detected edge; otherwise fire when the
  // countdown reaches its last step.
  assign fire = (start && settle == '0) || (!start && busy && remain == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
      busy   <= 1'b0;
    end else if (start) begin
      remain <= settle;
      busy   <= (settle != '0);
    end else if (busy) begin
      remain <= remain - ONE;
      if (remain == ONE) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ccs_snapshot.sv
`timescale 1ns/1ps
module ccs_snapshot #(
  parameter int                  CNT_W       = 16,
  parameter int                  SYNC_STAGES = 2,
  parameter int                  SETTLE_W    = 4,
  parameter ccs_pkg::qual_mode_e QUAL_MODE   = ccs_pkg::QUAL_ANY_EDGE
) (
  input  logic                fast_clk,
  input  logic                fast_rst_n,
  input  logic [CNT_W-1:0]    slow_count,
  input  logic                slow_qual,
  input  logic [SETTLE_W-1:0] settle_cycles,
  input  logic                loc_inc,
  output logic [CNT_W-1:0]    snap_value,
  output logic                snap_strobe,
  output logic                snap_valid,
  output logic [CNT_W-1:0]    loc_count,
  output logic [CNT_W-1:0]    diff_value
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic qual_sync;
  logic qual_evt;
  logic load_now;

  ccs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (fast_clk),
    .rst_n (fast_rst_n),
    .d     (slow_qual),
    .q     (qual_sync)
  );

  ccs_edge #(.MODE(QUAL_MODE)) u_edge (
    .clk   (fast_clk),
    .rst_n (fast_rst_n),
    .lvl   (qual_sync),
    .pulse (qual_evt)
  );

  ccs_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk    (fast_clk),
    .rst_n  (fast_rst_n),
    .start  (qual_evt),
    .settle (settle_cycles),
    .fire   (load_now)
  );

  // Holding register: the bus is sampled only on a qualified, delayed strobe.
  always_ff @(posedge fast_clk or negedge fast_rst_n) begin
    if (!fast_rst_n) begin
      snap_value  <= '0;
      snap_valid  <= 1'b0;
      snap_strobe <= 1'b0;
    end else begin
      snap_strobe <= load_now;
      if (load_now) begin
        snap_value <= slow_count;
        snap_valid <= 1'b1;
      end
    end
  end

  // Local fast-domain counter.
  always_ff @(posedge fast_clk or negedge fast_rst_n) begin
    if (!fast_rst_n)  loc_count <= '0;
    else if (loc_inc) loc_count <= loc_count + CNT_ONE;
  end

  // Difference follows the strobe by one cycle.
  always_ff @(posedge fast_clk or negedge fast_rst_n) begin
    if (!fast_rst_n)      diff_value <= '0;
    else if (snap_strobe) diff_value <= snap_value - loc_count;
  end
endmodule

// File: rtl/ccs_snapshot_chk.sv
`timescale 1ns/1ps
module ccs_snapshot_chk #(
  parameter int CNT_W = 16
) (
  input logic             fast_clk,
  input logic             fast_rst_n,
  input logic             loc_inc,
  input logic [CNT_W-1:0] snap_value,
  input logic             snap_strobe,
  input logic             snap_valid,
  input logic [CNT_W-1:0] loc_count,
  input logic [CNT_W-1:0] diff_value
);
  p_snap_hold_r4: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    !snap_strobe |-> $stable(snap_value));

  p_strobe_valid_r5: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    snap_strobe |-> snap_valid);

  p_valid_sticky_r5: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    $fell(snap_valid) |-> 1'b0 == 1'b1 && !fast_rst_n);

  p_valid_first_r6: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    $rose(snap_valid) |-> snap_strobe);

  p_loc_step_r7: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    ($past(fast_rst_n) && $past(loc_inc)) |-> loc_count == $past(loc_count) + CNT_W'(1));

  p_diff_update_r8: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    $past(snap_strobe) |-> diff_value == $past(snap_value) - $past(loc_count));

  p_diff_hold_r8: assert property (@(posedge fast_clk) disable iff (!fast_rst_n)
    !$past(snap_strobe) |-> $stable(diff_value));
endmodule

bind ccs_snapshot ccs_snapshot_chk #(.CNT_W(CNT_W)) u_chk (
  .fast_clk    (fast_clk),
  .fast_rst_n  (fast_rst_n),
  .loc_inc     (loc_inc),
  .snap_value  (snap_value),
  .snap_strobe (snap_strobe),
  .snap_valid  (snap_valid),
  .loc_count   (loc_count),
  .diff_value  (diff_value)
);

// File: tb/ccs_snapshot_tb_top.sv
`timescale 1ns/1ps
module ccs_snapshot_tb_top;
  localparam int W    = 16;
  localparam int SYNC = 2;
  localparam int SW   = 4;

  logic          fast_clk = 1'b0;
  logic          slow_clk = 1'b0;
  logic          fast_rst_n = 1'b0;
  logic [W-1:0]  slow_count = 16'hFFE0;
  logic          slow_qual = 1'b0;
  logic [SW-1:0] settle_cycles = '0;
  logic          loc_inc = 1'b0;
  logic [W-1:0]  snap_value;
  logic          snap_strobe;
  logic          snap_valid;
  logic [W-1:0]  loc_count;
  logic [W-1:0]  diff_value;

  int checks = 0, fails = 0, captures = 0, pushes = 0, lag = 0;
  bit lag_armed = 0, slow_run = 0, mon_on = 0;
  bit prev_inc = 0, prev_strobe = 0, diff_due = 0;
  logic [W-1:0] model_cnt = 16'hFFE0;
  logic [W-1:0] exp_loc = '0, exp_diff = '0, last_diff = '0, last_snap = '0;
  logic [W-1:0] exp_q[$];

  ccs_snapshot #(.CNT_W(W), .SYNC_STAGES(SYNC), .SETTLE_W(SW)) dut_i (
    .fast_clk, .fast_rst_n, .slow_count, .slow_qual, .settle_cycles,
    .loc_inc, .snap_value, .snap_strobe, .snap_valid, .loc_count, .diff_value
  );

  always #5 fast_clk = ~fast_clk;

  initial begin
    real ph;
    ph = real'($urandom % 700) + 0.3;
    #(ph);
    forever #386.5 slow_clk = ~slow_clk;
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Driver: slow counter with skewed bus bits; qualifier (LSB) moves last.
  task automatic slow_step();
    model_cnt = model_cnt + 1'b1;
    slow_count[W-1:W/2] = model_cnt[W-1:W/2];
    #1;
    slow_count[W/2-1:0] = model_cnt[W/2-1:0];
    #1;
    slow_qual = model_cnt[0];
    exp_q.push_back(model_cnt);
    pushes++;
    lag = 0;
    lag_armed = 1;
  endtask

  always @(posedge slow_clk) if (slow_run) slow_step();

  always @(posedge fast_clk) if (lag_armed) lag++;

  // Monitor / scoreboard
  always @(negedge fast_clk) begin
    if (mon_on) begin
      logic [W-1:0] exp_v;
      exp_loc = exp_loc + W'(prev_inc);
      check(loc_count == exp_loc, "R7 loc_count", loc_count, exp_loc);
      if (diff_due) check(diff_value == exp_diff, "R8 diff after strobe", diff_value, exp_diff);
      else          check(diff_value == last_diff, "R8 diff hold", diff_value, last_diff);
      last_diff = diff_value;
      diff_due = 0;
      if (snap_strobe) begin
        check(!prev_strobe, "R5 strobe width", 32'(prev_strobe), 0);
        check(snap_valid, "R5 valid with strobe", 32'(snap_valid), 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected capture", snap_value, 0);
        end else begin
          exp_v = exp_q.pop_front();
          check(snap_value == exp_v, "R4 captured value", snap_value, exp_v);
        end
        check(lag == SYNC + 1 + int'(settle_cycles), "R3 R9 capture lag",
              lag, SYNC + 1 + int'(settle_cycles));
        lag_armed = 0;
        exp_diff = snap_value - loc_count;  // loc_count of the strobe cycle
        diff_due = 1;
        last_snap = snap_value;
        captures++;
      end else begin
        check(snap_value == last_snap, "R4 snapshot hold", snap_value, last_snap);
      end
      prev_strobe = snap_strobe;
      loc_inc = 1'($urandom % 2);
      prev_inc = loc_inc;
    end
  end

  initial begin
    repeat (150000) @(posedge fast_clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", captures, 60);
    finish_run();
  end

  initial begin
    repeat (10) @(negedge fast_clk);
    check(snap_value == 0 && diff_value == 0 && loc_count == 0, "R1 reset values",
          {snap_value, diff_value}, 0);
    check(!snap_strobe && !snap_valid, "R1 reset flags", {snap_strobe, snap_valid}, 0);
    fast_rst_n = 1'b1;
    @(negedge fast_clk);
    check(snap_value == 0 && diff_value == 0 && loc_count == 0, "R1 after release",
          {snap_value, loc_count}, 0);
    check(!snap_strobe && !snap_valid, "R1 flags after release",
          {snap_strobe, snap_valid}, 0);
    mon_on = 1;
    repeat (200) begin
      @(negedge fast_clk);
      check(!snap_valid, "R6 valid stays low", 32'(snap_valid), 0);
    end
    slow_run = 1;
    wait (captures >= 10);
    settle_cycles = 4'd3;
    wait (captures >= 25);
    settle_cycles = 4'd7;
    wait (captures >= 40);
    settle_cycles = 4'd15;
    wait (pushes >= 60);
    slow_run = 0;
    repeat (400) @(negedge fast_clk);
    check(exp_q.size() == 0, "R2 all changes captured", exp_q.size(), 0);
    check(captures == pushes, "R2 one capture per change", captures, pushes);
    check(snap_valid, "R5 valid sticky", 32'(snap_valid), 1);
    finish_run();
  end
endmodule